// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks the pending ones against the levels already being serviced, and raises a single interrupt output toward a processor. The processor answers with an acknowledge pulse. During that pulse the block presents an 8-bit vector: a programmable upper part and the number of the granted line in the low three bits. At the clock edge that ends the pulse, it moves that line from pending to in-service.

Software drives the block through an 8-bit write/read port with a single address bit. An initialization sequence of two to four words sets the vector base, the sensing mode (edge or level) and the end-of-interrupt style, and any initialization word may be skipped according to the first word. After that, writes load the mask, issue end-of-interrupt and priority commands, or select readback, polling and special masking. Priority is fixed (line 0 first) after initialization and can be rotated. Cascade and buffer settings are accepted and stored but drive nothing.

Top module: `pic8_top`

## Requirements
- R1: After reset the interrupt output is low and stays low until an initialization sequence has completed; the mask reads 0x00 and an even-address read returns the pending register, which is 0x00.
- R2: An even-address write with bit 4 set starts initialization and clears the mask; the next odd-address write sets the vector base (bits 7:3); a third (cascade) word follows only if the first word had bit 1 clear, and a last word follows only if bit 0 was set; the next odd-address write after that loads the mask.
- R3: While the acknowledge input is high, the vector output equals {base[4:0], granted level[2:0]}.
- R4: An odd-address write in operating mode loads the mask (1 blocks a line); a masked pending line never raises the interrupt output; an odd-address read returns the mask.
- R5: The interrupt output is high only when an unmasked pending line ranks strictly above every in-service level; after initialization line 0 ranks highest and line 7 lowest.
- R6: In edge mode (first word bit 3 = 0) a rising input edge stays pending until acknowledged, and a line held high does not request again; in level mode (bit 3 = 1) the pending bit follows the input.
- R7: An acknowledge clears the granted line from the pending register and sets it in the in-service register; a write with bits 4:3 = 01 and bit 1 set selects the pending register (bit 0 = 1) or the in-service register (bit 0 = 0) for even-address reads.
- R8: An operation write with bits 4:3 = 00 and code 001 in bits 7:5 clears the highest-ranked in-service bit; code 011 clears the in-service bit named in bits 2:0.
- R9: Code 101 clears the highest-ranked in-service bit and makes that level the lowest priority; code 111 does the same for the level in bits 2:0; code 110 only makes the level in bits 2:0 the lowest priority.
- R10: With automatic end-of-interrupt (last init word bit 1 = 1) an acknowledge leaves the in-service register unchanged; code 100 enables rotation of the granted level to lowest priority on each acknowledge, code 000 disables it.
- R11: A status write with bit 2 set arms a poll; the next even-address read returns 0x80 ORed with the winning level and services it like an acknowledge, or 0x00 when no request would raise the interrupt.
- R12: A status write with bit 6 set loads special mask mode from bit 5; in that mode, in-service levels whose mask bit is set do not block lower-ranked requests.
- R13: Code 010 changes nothing, and a status write with bit 1 clear leaves the read selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Register write strobe, one cycle |
| rd_i | input | 1 | Register read strobe, one cycle |
| addr_i | input | 1 | Register address bit (0 even, 1 odd) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_i | input | 8 | Interrupt request lines |
| ack_i | input | 1 | Interrupt acknowledge pulse, one cycle |
| int_o | output | 1 | Interrupt request toward the processor |
| vec_o | output | 8 | Vector, valid while ack_i is high |

## Verification
A corrupted in-service register shows up at once on the interrupt output: a stale bit holds back lower-ranked requests that should fire, and a lost bit lets them interrupt a handler that should not be interrupted. A wrong rotation pointer appears at the next acknowledge, when two pending lines are granted in the wrong order and the vector's low bits are wrong. Mask, pending and in-service faults can also be read back on the next read strobe. Each scenario therefore pairs two simultaneous requests with a vector check and an explicit readback of the affected register.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_W2     = 3'd1,
        ST_W3     = 3'd2,
        ST_W4     = 3'd3,
        ST_RUN    = 3'd4
    } pic8_init_e;

    // end-of-interrupt command codes, bits 7:5 of an operation write
    localparam logic [2:0] CMD_ROT_AEOI_CLR = 3'b000;
    localparam logic [2:0] CMD_EOI_NS       = 3'b001;
    localparam logic [2:0] CMD_NOP          = 3'b010;
    localparam logic [2:0] CMD_EOI_SP       = 3'b011;
    localparam logic [2:0] CMD_ROT_AEOI_SET = 3'b100;
    localparam logic [2:0] CMD_ROT_NS       = 3'b101;
    localparam logic [2:0] CMD_SET_PRIO     = 3'b110;
    localparam logic [2:0] CMD_ROT_SP       = 3'b111;

endpackage

// File: rtl/pic8_prio_pick.sv
// Finds the highest-ranked set bit of a vector under a rotating order.
// The level after low_i ranks first (rank 0); low_i itself ranks last.
module pic8_prio_pick #(
    parameter int NUM_IRQ = 8,
    parameter int LVL_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] vec_i,
    input  logic [LVL_W-1:0]   low_i,
    output logic               valid_o,
    output logic [LVL_W-1:0]   lvl_o,
    output logic [LVL_W-1:0]   rank_o
);
    always_comb begin
        valid_o = 1'b0;
        lvl_o   = '0;
        rank_o  = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            if (vec_i[LVL_W'(low_i + LVL_W'(k + 1))]) begin
                valid_o = 1'b1;
                lvl_o   = LVL_W'(low_i + LVL_W'(k + 1));
                rank_o  = LVL_W'(k);
            end
        end
    end
endmodule

// File: rtl/pic8_req_latch.sv
// Pending-request register with edge or level sensing.
module pic8_req_latch #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               lvl_mode_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] irr_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] prev;
        logic [NUM_IRQ-1:0] irr;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d.prev = irq_i;
        if (lvl_mode_i) begin
            lat_d.irr = irq_i & ~clr_i;
        end else begin
            lat_d.irr = (lat_q.irr | (irq_i & ~lat_q.prev)) & ~clr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign irr_o = lat_q.irr;

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode_i && clr_i == '0) |=> ((lat_q.irr & $past(lat_q.irr)) == $past(lat_q.irr)));
endmodule

// File: rtl/pic8_top.sv
module pic8_top #(
    parameter int NUM_IRQ = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic               addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               ack_i,
    output logic               int_o,
    output logic [DATA_W-1:0]  vec_o
);
    import pic8_pkg::*;

    // NUM_IRQ must be a power of two and equal DATA_W for the command fields
    localparam int LVL_W  = $clog2(NUM_IRQ);
    localparam int BASE_W = DATA_W - LVL_W;
    localparam int PAD_W  = DATA_W - 1 - LVL_W;

    typedef struct packed {
        pic8_init_e          st;
        logic                ltim;
        logic                sngl;
        logic                ic4;
        logic                aeoi;
        logic                sfnm;
        logic [2:0]          mode4;
        logic [BASE_W-1:0]   base;
        logic [DATA_W-1:0]   cas;
        logic [NUM_IRQ-1:0]  imr;
        logic [NUM_IRQ-1:0]  isr;
        logic [LVL_W-1:0]    low;
        logic                rot_aeoi;
        logic                smm;
        logic                sel_irr;
        logic                poll;
    } ctl_t;

    ctl_t d, q;

    logic [NUM_IRQ-1:0] irr, irr_clr;
    logic               cand_v, eff_v, hi_v;
    logic [LVL_W-1:0]   cand_lvl, cand_rank, eff_lvl, eff_rank, hi_lvl, hi_rank;
    logic               int_w, poll_rd, svc;
    logic [LVL_W-1:0]   cmd_lvl;

    pic8_req_latch #(.NUM_IRQ(NUM_IRQ)) u_lat (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .lvl_mode_i(q.ltim),
        .clr_i(irr_clr), .irr_o(irr)
    );

    pic8_prio_pick #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_cand (
        .vec_i(irr & ~q.imr), .low_i(q.low),
        .valid_o(cand_v), .lvl_o(cand_lvl), .rank_o(cand_rank)
    );

    pic8_prio_pick #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_block (
        .vec_i(q.smm ? (q.isr & ~q.imr) : q.isr), .low_i(q.low),
        .valid_o(eff_v), .lvl_o(eff_lvl), .rank_o(eff_rank)
    );

    pic8_prio_pick #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_eoi (
        .vec_i(q.isr), .low_i(q.low),
        .valid_o(hi_v), .lvl_o(hi_lvl), .rank_o(hi_rank)
    );

    assign int_w   = (q.st == ST_RUN) && cand_v && (!eff_v || (cand_rank < eff_rank));
    assign poll_rd = rd_i && !addr_i && q.poll;
    assign svc     = int_w && (ack_i || poll_rd);
    assign cmd_lvl = wdata_i[LVL_W-1:0];

    always_comb begin
        d       = q;
        irr_clr = '0;
        if (poll_rd) d.poll = 1'b0;
        if (svc) begin
            irr_clr[cand_lvl] = 1'b1;
            if (!q.aeoi)         d.isr[cand_lvl] = 1'b1;
            else if (q.rot_aeoi) d.low = cand_lvl;
        end
        if (wr_i) begin
            if (!addr_i && wdata_i[4]) begin
                d.st       = ST_W2;
                d.ic4      = wdata_i[0];
                d.sngl     = wdata_i[1];
                d.ltim     = wdata_i[3];
                d.aeoi     = 1'b0;
                d.sfnm     = 1'b0;
                d.imr      = '0;
                d.isr      = '0;
                d.low      = '1;
                d.rot_aeoi = 1'b0;
                d.smm      = 1'b0;
                d.sel_irr  = 1'b1;
                d.poll     = 1'b0;
                irr_clr    = '1;
            end else begin
                case (q.st)
                    ST_W2: if (addr_i) begin
                        d.base = wdata_i[DATA_W-1:LVL_W];
                        d.st   = !q.sngl ? ST_W3 : (q.ic4 ? ST_W4 : ST_RUN);
                    end
                    ST_W3: if (addr_i) begin
                        d.cas = wdata_i;
                        d.st  = q.ic4 ? ST_W4 : ST_RUN;
                    end
                    ST_W4: if (addr_i) begin
                        d.aeoi  = wdata_i[1];
                        d.sfnm  = wdata_i[4];
                        d.mode4 = {wdata_i[3:2], wdata_i[0]};
                        d.st    = ST_RUN;
                    end
                    ST_RUN: begin
                        if (addr_i) begin
                            d.imr = wdata_i[NUM_IRQ-1:0];
                        end else if (wdata_i[4:3] == 2'b00) begin
                            case (wdata_i[7:5])
                                CMD_EOI_NS:       if (hi_v) d.isr[hi_lvl] = 1'b0;
                                CMD_ROT_NS:       if (hi_v) begin
                                    d.isr[hi_lvl] = 1'b0;
                                    d.low         = hi_lvl;
                                end
                                CMD_EOI_SP:       d.isr[cmd_lvl] = 1'b0;
                                CMD_ROT_SP: begin
                                    d.isr[cmd_lvl] = 1'b0;
                                    d.low          = cmd_lvl;
                                end
                                CMD_SET_PRIO:     d.low = cmd_lvl;
                                CMD_ROT_AEOI_SET: d.rot_aeoi = 1'b1;
                                CMD_ROT_AEOI_CLR: d.rot_aeoi = 1'b0;
                                default:          ;
                            endcase
                        end else if (wdata_i[4:3] == 2'b01) begin
                            if (wdata_i[1]) d.sel_irr = wdata_i[0];
                            if (wdata_i[2]) d.poll    = 1'b1;
                            if (wdata_i[6]) d.smm     = wdata_i[5];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_UNINIT;
            q.low     <= '1;
            q.sel_irr <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (addr_i)       rdata_o = DATA_W'(q.imr);
        else if (q.poll)  rdata_o = {int_w, {PAD_W{1'b0}}, (int_w ? cand_lvl : {LVL_W{1'b0}})};
        else if (q.sel_irr) rdata_o = DATA_W'(irr);
        else              rdata_o = DATA_W'(q.isr);
    end

    assign int_o = int_w;
    assign vec_o = {q.base, (int_w ? cand_lvl : {LVL_W{1'b1}})};

    // R2
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_i && wdata_i[4]) |=> !int_o);
    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !q.imr[cand_lvl]);
    // R7
    ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && !q.aeoi && !wr_i) |=> (q.isr != '0));
    // R10
    aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && q.aeoi && !wr_i) |=> (q.isr == $past(q.isr)));
    // R11
    poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !addr_i && q.poll && !wr_i) |=> !q.poll);
endmodule

// File: tb/pic8_top_tb_top.sv
module pic8_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_r = 1'b0, rd_r = 1'b0, addr_r = 1'b0, ack_r = 1'b0;
    logic [7:0] wdata_r = '0, irq_r = '0;
    logic [7:0] rdata, vec;
    logic       intr;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pic8_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_r), .rd_i(rd_r), .addr_i(addr_r),
        .wdata_i(wdata_r), .rdata_o(rdata), .irq_i(irq_r), .ack_i(ack_r),
        .int_o(intr), .vec_o(vec)
    );

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sbq.pop_front();
                case (it.sel)
                    0:       got = {7'd0, intr};
                    1:       got = vec;
                    default: got = rdata;
                endcase
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got 0x%02h expected 0x%02h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [7:0] e, input string req);
        item_t it;
        it.sel = sel; it.exp = e; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic a, input logic [7:0] dv);
        wr_r = 1'b1; addr_r = a; wdata_r = dv;
        @(negedge clk);
        wr_r = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] e, input string req);
        rd_r = 1'b1; addr_r = a;
        push(2, e, req);
        @(negedge clk);
        rd_r = 1'b0;
    endtask

    task automatic ack_chk(input logic [7:0] e, input string req);
        ack_r = 1'b1;
        push(1, e, req);
        @(negedge clk);
        ack_r = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_r = v;
        @(negedge clk);
    endtask

    task automatic chk_int(input logic e, input string req);
        push(0, {7'd0, e}, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int(1'b0, "R1 int after reset");
        rd_chk(1'b1, 8'h00, "R1 mask after reset");
        rd_chk(1'b0, 8'h00, "R1 pending after reset");
        set_irq(8'h08);
        chk_int(1'b0, "R1 no int before init");
        set_irq(8'h00);

        // edge mode, single, last word present
        wr(1'b0, 8'h13);
        chk_int(1'b0, "R2 quiet during init");
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h5A);
        rd_chk(1'b1, 8'h5A, "R2 cascade word skipped");
        wr(1'b1, 8'h00);

        set_irq(8'h08);
        chk_int(1'b1, "R5 single request");
        ack_chk(8'h23, "R3 vector line 3");
        chk_int(1'b0, "R7 int drops after ack");
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h08, "R7 in-service after ack");
        wr(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h00, "R6 held line not pending again");

        set_irq(8'h28);
        chk_int(1'b0, "R5 lower request blocked");
        set_irq(8'h2A);
        chk_int(1'b1, "R5 higher request nests");
        ack_chk(8'h21, "R3 vector line 1");
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h0A, "R7 two in service");
        wr(1'b0, 8'h20);
        rd_chk(1'b0, 8'h08, "R8 non-specific clears highest");
        chk_int(1'b0, "R8 line 5 still blocked");
        wr(1'b0, 8'h63);
        chk_int(1'b1, "R8 specific eoi unblocks");
        ack_chk(8'h25, "R8 vector line 5");
        wr(1'b0, 8'h65);
        chk_int(1'b0, "R8 all serviced");

        set_irq(8'h00);
        wr(1'b1, 8'h10);
        set_irq(8'h10);
        chk_int(1'b0, "R4 masked line silent");
        rd_chk(1'b1, 8'h10, "R4 mask readback");
        wr(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h10, "R4 masked line pending");
        wr(1'b1, 8'h00);
        chk_int(1'b1, "R4 unmask raises int");
        ack_chk(8'h24, "R4 vector line 4");
        wr(1'b0, 8'h20);

        set_irq(8'h00);
        wr(1'b0, 8'hC4);
        set_irq(8'h41);
        ack_chk(8'h26, "R9 set priority order");
        chk_int(1'b0, "R9 line 0 ranks below 6");
        wr(1'b0, 8'hA0);
        chk_int(1'b1, "R9 rotate non-specific");
        ack_chk(8'h20, "R9 vector line 0");
        wr(1'b0, 8'hE0);
        set_irq(8'h00);
        set_irq(8'h03);
        ack_chk(8'h21, "R9 rotate specific order");
        chk_int(1'b0, "R9 line 0 now lowest");
        wr(1'b0, 8'h61);
        ack_chk(8'h20, "R9 vector line 0 later");
        wr(1'b0, 8'h60);
        wr(1'b0, 8'hC7);
        set_irq(8'h00);

        wr(1'b0, 8'h0C);
        rd_chk(1'b0, 8'h00, "R11 poll with nothing");
        set_irq(8'h04);
        wr(1'b0, 8'h0C);
        rd_chk(1'b0, 8'h82, "R11 poll result");
        chk_int(1'b0, "R11 poll serviced");
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h04, "R11 poll sets in-service");
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        set_irq(8'h08);
        ack_chk(8'h23, "R12 vector line 3");
        wr(1'b1, 8'h08);
        wr(1'b0, 8'h68);
        set_irq(8'h28);
        chk_int(1'b1, "R12 masked level ignored");
        ack_chk(8'h25, "R12 vector line 5");
        wr(1'b0, 8'h48);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h20, "R12 non-specific after special mask");
        wr(1'b0, 8'h20);
        wr(1'b1, 8'h00);
        set_irq(8'h00);

        set_irq(8'h08);
        ack_chk(8'h23, "R13 vector line 3");
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h08, "R13 no-op keeps in-service");
        wr(1'b0, 8'h09);
        rd_chk(1'b0, 8'h08, "R13 select unchanged");
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // level mode with automatic end-of-interrupt
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h1B);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        rd_chk(1'b1, 8'h00, "R2 init clears mask");
        set_irq(8'h04);
        chk_int(1'b1, "R6 level request");
        set_irq(8'h00);
        chk_int(1'b0, "R6 level request withdrawn");
        set_irq(8'h04);
        ack_chk(8'h42, "R3 new base");
        set_irq(8'h00);
        wr(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h00, "R10 auto eoi leaves nothing");
        wr(1'b0, 8'h80);
        set_irq(8'h09);
        ack_chk(8'h40, "R10 vector line 0");
        ack_chk(8'h43, "R10 rotation after ack");
        wr(1'b0, 8'h00);
        set_irq(8'h30);
        ack_chk(8'h44, "R10 vector line 4");
        set_irq(8'h30);
        ack_chk(8'h44, "R10 rotation disabled");
        set_irq(8'h00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule